// File: doc/BRIEF.md
# Channel-Merged Convolution Line Buffer

This block sits in front of a k×k convolution engine and turns a raster stream of quantized activations into complete convolution windows. Activations arrive in row order, and the channels of each pixel arrive together before the next pixel starts. Every input beat carries PI adjacent channels of one pixel. The block keeps the most recent k image rows. Each stored row is one flat array indexed by pixel column and channel group together, so a single storage array serves every channel count up to the design limit.

For each accepted beat from row k−1 onwards, the block presents one window on its output handshake. The window holds the k×k neighbourhood that ends at that pixel, for the same PI channels as the beat. Columns to the left of the image are filled with zeros. Image width, channel count and kernel size come in on configuration ports. They are captured on the first beat of a frame, which is flagged by a start-of-frame bit. When the kernel size is 1, storage is skipped and the beat passes straight to the output.

Top module: `conv_line_buffer`

## Requirements
- R1: Inside a row, beats are addressed as pixel × (C/PI) + channel group, with the group advancing fastest. The window for a beat at column x and group g takes every tap from group g, at columns x−k+1 through x.
- R2: The buffer rotates among exactly k row slots. Window row r (0 = top) holds image row y−k+1+r, where y is the row of the current beat.
- R3: Tap (r, j) lane l occupies out_win_o bits [((r·K_MAX+j)·PI+l)·QA +: QA], with j = 0 the leftmost column. Taps with r ≥ k or j ≥ k are zero.
- R4: For k > 1, no window is produced for the beats of the first k−1 rows of a frame. The first window appears in the cycle after the first beat of row k−1 is accepted.
- R5: Taps whose column lies left of column 0 are zero.
- R6: With k = 1 the output is combinational: out_valid_o follows in_valid_i in the same cycle, tap 0 equals in_data_i, and in_ready_o follows out_ready_i.
- R7: While out_valid_o is high and out_ready_i is low, in_ready_o is low and the presented window stays unchanged.
- R8: width_i, chan_i and ksize_i are used only on an accepted beat with in_sof_i high. Their values on every other beat have no effect.
- R9: After reset, out_valid_o is low.
- R10: Lane l of a beat for channel group g carries channel g·PI + l. C must be a multiple of PI, and W·C must not exceed W_MAX·C_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_i | input | $clog2(W_MAX+1) | Image width in pixels, captured at frame start |
| chan_i | input | $clog2(C_MAX+1) | Channel count, captured at frame start |
| ksize_i | input | $clog2(K_MAX+1) | Kernel size k, captured at frame start |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| in_sof_i | input | 1 | Marks the first beat of a frame |
| in_data_i | input | PI·QA | PI activations of one pixel |
| out_valid_o | output | 1 | Window valid |
| out_ready_i | input | 1 | Engine takes the window |
| out_win_o | output | K_MAX²·PI·QA | Window taps |

## Verification
A window that is stalled on the output side and a new input beat can meet in the same cycle. The bench drives an irregular out_ready_i pattern together with gaps in in_valid_i, so these collisions happen throughout every frame. In each such cycle it requires in_ready_o to be low, and it compares each window that drains against the expected window for its beat. Frame starts are also issued right after the last window of the previous frame has left. The bench drives misleading configuration values on every other beat, and then checks that the new frame's windows follow only the values presented with the start flag.

// File: rtl/lb_pkg.sv
package lb_pkg;
  function automatic int tap_lsb(int r, int j, int l, int kmax, int pi, int qa);
    return ((r * kmax + j) * pi + l) * qa;
  endfunction
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl #(
  parameter int PI    = 2,
  parameter int K_MAX = 3,
  parameter int WW    = 4,
  parameter int CW    = 3,
  parameter int KW    = 2,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_sof_i,
  input  logic          acc_i,
  input  logic [WW-1:0] width_i,
  input  logic [CW-1:0] chan_i,
  input  logic [KW-1:0] ksize_i,
  output logic [KW-1:0] k_o,
  output logic [CW-1:0] gn_o,
  output logic [WW-1:0] x_o,
  output logic [KW-1:0] slot_o,
  output logic [AW-1:0] addr_o,
  output logic          full_o
);
  logic [WW-1:0] w_q, w_e, x_q, x_e, x_n;
  logic [CW-1:0] gn_q, gn_e, grp_q, grp_e, grp_n;
  logic [KW-1:0] k_q, k_e, slot_q, slot_e, slot_n, rows_q, rows_e, rows_n;
  logic [AW-1:0] addr_q, addr_e, addr_n;

  // first beat of a frame sees fresh config and a zeroed position
  always_comb begin
    int gi, xi, si, ri, ai;
    w_e    = vld_sof_i ? width_i : w_q;
    gn_e   = vld_sof_i ? CW'(int'(chan_i) / PI) : gn_q;
    k_e    = vld_sof_i ? ksize_i : k_q;
    x_e    = vld_sof_i ? '0 : x_q;
    grp_e  = vld_sof_i ? '0 : grp_q;
    slot_e = vld_sof_i ? '0 : slot_q;
    rows_e = vld_sof_i ? '0 : rows_q;
    addr_e = vld_sof_i ? '0 : addr_q;
    gi = int'(grp_e) + 1;
    xi = int'(x_e);
    si = int'(slot_e);
    ri = int'(rows_e);
    ai = int'(addr_e) + 1;
    if (gi >= int'(gn_e)) begin
      gi = 0;
      xi = xi + 1;
      if (xi >= int'(w_e)) begin
        xi = 0;
        ai = 0;
        si = si + 1;
        if (si >= int'(k_e)) si = 0;
        if (ri < K_MAX - 1) ri = ri + 1;
      end
    end
    grp_n  = CW'(gi);
    x_n    = WW'(xi);
    slot_n = KW'(si);
    rows_n = KW'(ri);
    addr_n = AW'(ai);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      gn_q   <= '0;
      k_q    <= KW'(1);
      x_q    <= '0;
      grp_q  <= '0;
      slot_q <= '0;
      rows_q <= '0;
      addr_q <= '0;
    end else if (acc_i) begin
      if (vld_sof_i) begin
        w_q  <= w_e;
        gn_q <= gn_e;
        k_q  <= k_e;
      end
      x_q    <= x_n;
      grp_q  <= grp_n;
      slot_q <= slot_n;
      rows_q <= rows_n;
      addr_q <= addr_n;
    end
  end

  assign k_o    = k_e;
  assign gn_o   = gn_e;
  assign x_o    = x_e;
  assign slot_o = slot_e;
  assign addr_o = addr_e;
  assign full_o = (int'(rows_e) + 1) >= int'(k_e);
endmodule

// File: rtl/lb_store.sv
module lb_store #(
  parameter int QA    = 8,
  parameter int PI    = 2,
  parameter int K_MAX = 3,
  parameter int ROW_W = 16,
  parameter int WW    = 4,
  parameter int CW    = 3,
  parameter int KW    = 2,
  parameter int AW    = 5,
  localparam int DW   = PI * QA,
  localparam int SW   = $clog2(K_MAX),
  localparam int RW   = $clog2(ROW_W),
  localparam int WINW = K_MAX * K_MAX * DW
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [KW-1:0]   k_i,
  input  logic [CW-1:0]   gn_i,
  input  logic [WW-1:0]   x_i,
  input  logic [KW-1:0]   slot_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   din_i,
  output logic [WINW-1:0] win_o
);
  logic [DW-1:0] mem_q [K_MAX][ROW_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[SW'(slot_i)][RW'(addr_i)] <= din_i;
  end

  for (genvar r = 0; r < K_MAX; r++) begin : g_row
    for (genvar j = 0; j < K_MAX; j++) begin : g_col
      logic [DW-1:0] tap;
      always_comb begin
        int kk, m, s, a;
        kk = int'(k_i);
        m  = kk - 1 - j;
        s  = int'(slot_i) + r + 1;
        if (s >= kk) s = s - kk;
        a  = int'(addr_i) - m * int'(gn_i);
        tap = '0;
        if (r < kk && j < kk && int'(x_i) >= m) begin
          if (r == kk - 1 && j == kk - 1) tap = din_i;
          else if (s >= 0 && s < K_MAX && a >= 0 && a < ROW_W) tap = mem_q[SW'(s)][RW'(a)];
        end
      end
      assign win_o[(r*K_MAX+j)*DW +: DW] = tap;
    end
  end
endmodule

// File: rtl/conv_line_buffer.sv
module conv_line_buffer #(
  parameter int QA    = 8,
  parameter int PI    = 2,
  parameter int W_MAX = 8,
  parameter int C_MAX = 4,
  parameter int K_MAX = 3,
  localparam int WW    = $clog2(W_MAX + 1),
  localparam int CW    = $clog2(C_MAX + 1),
  localparam int KW    = $clog2(K_MAX + 1),
  localparam int ROW_W = W_MAX * (C_MAX / PI),
  localparam int AW    = $clog2(ROW_W + 1),
  localparam int DW    = PI * QA,
  localparam int WINW  = K_MAX * K_MAX * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WW-1:0]   width_i,
  input  logic [CW-1:0]   chan_i,
  input  logic [KW-1:0]   ksize_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            in_sof_i,
  input  logic [DW-1:0]   in_data_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [WINW-1:0] out_win_o
);
  logic            vld_sof, byp, acc, load_win, full, out_vld_q;
  logic [KW-1:0]   k_e, slot_e;
  logic [CW-1:0]   gn_e;
  logic [WW-1:0]   x_e;
  logic [AW-1:0]   addr_e;
  logic [WINW-1:0] win_c, win_q;

  assign vld_sof = in_valid_i & in_sof_i;

  lb_ctrl #(.PI(PI), .K_MAX(K_MAX), .WW(WW), .CW(CW), .KW(KW), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .vld_sof_i(vld_sof), .acc_i(acc),
    .width_i, .chan_i, .ksize_i,
    .k_o(k_e), .gn_o(gn_e), .x_o(x_e), .slot_o(slot_e), .addr_o(addr_e), .full_o(full)
  );

  lb_store #(.QA(QA), .PI(PI), .K_MAX(K_MAX), .ROW_W(ROW_W), .WW(WW), .CW(CW), .KW(KW),
             .AW(AW)) u_store (
    .clk_i, .we_i(acc & ~byp), .k_i(k_e), .gn_i(gn_e), .x_i(x_e), .slot_i(slot_e),
    .addr_i(addr_e), .din_i(in_data_i), .win_o(win_c)
  );

  assign byp        = (k_e == KW'(1));
  // bypass needs the output register drained before passing through
  assign in_ready_o = byp ? (out_ready_i & ~out_vld_q) : (~out_vld_q | out_ready_i);
  assign acc        = in_valid_i & in_ready_o;
  assign load_win   = acc & ~byp & full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      win_q     <= '0;
    end else begin
      if (load_win) begin
        out_vld_q <= 1'b1;
        win_q     <= win_c;
      end else if (out_ready_i) begin
        out_vld_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_vld_q | (byp & in_valid_i);
  assign out_win_o   = out_vld_q ? win_q : WINW'(in_data_i);
endmodule

// File: rtl/lb_chk.sv
module lb_chk #(
  parameter int QA    = 8,
  parameter int PI    = 2,
  parameter int K_MAX = 3,
  parameter int KW    = 2,
  localparam int WINW = K_MAX * K_MAX * PI * QA
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            in_sof_i,
  input logic [KW-1:0]   ksize_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [WINW-1:0] out_win_o,
  input logic            out_vld_q,
  input logic [KW-1:0]   cfg_k,
  input logic [KW-1:0]   slot_q
);
  import lb_pkg::*;
  logic [WINW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int r = 0; r < K_MAX; r++)
      for (int j = 0; j < K_MAX; j++)
        for (int l = 0; l < PI; l++)
          if (r >= int'(cfg_k) || j >= int'(cfg_k))
            mask[tap_lsb(r, j, l, K_MAX, PI, QA) +: QA] = '1;
  end

  a_r7_stall_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r7_window_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_q && !out_ready_i) |=> (out_valid_o && $stable(out_win_o)));

  a_r8_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_sof_i && in_ready_o) |=> $stable(cfg_k));

  a_r2_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_k != '0) |-> (slot_q < cfg_k));

  a_r4_no_early_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && in_ready_o && ksize_i > KW'(1)) |=> !out_vld_q);

  a_r3_unused_taps_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_q |-> ((out_win_o & mask) == '0));
endmodule

bind conv_line_buffer lb_chk #(.QA(QA), .PI(PI), .K_MAX(K_MAX), .KW(KW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_sof_i(in_sof_i), .ksize_i(ksize_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_win_o(out_win_o), .out_vld_q(out_vld_q), .cfg_k(u_ctrl.k_q), .slot_q(u_ctrl.slot_q)
);

// File: tb/sim_conv_line_buffer.sv
module sim_conv_line_buffer;
  localparam int CLK_P = 10;
  localparam int QA = 8, PI = 2, W_MAX = 8, C_MAX = 4, K_MAX = 3;
  localparam int WW = $clog2(W_MAX + 1), CW = $clog2(C_MAX + 1), KW = $clog2(K_MAX + 1);
  localparam int DW = PI * QA, WINW = K_MAX * K_MAX * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WW-1:0] width = '0;
  logic [CW-1:0] chan = '0;
  logic [KW-1:0] ksize = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [DW-1:0] in_data = '0;
  logic [WINW-1:0] out_win;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  conv_line_buffer #(.QA(QA), .PI(PI), .W_MAX(W_MAX), .C_MAX(C_MAX), .K_MAX(K_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .width_i(width), .chan_i(chan), .ksize_i(ksize),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_win_o(out_win)
  );

  function automatic logic [QA-1:0] pix(int f, int y, int x, int c);
    return QA'((y * 53 + x * 17 + c * 7 + f * 29 + 3) & 255);
  endfunction

  // R10: lane l of group g is channel g*PI+l; R1: group runs fastest
  function automatic logic [DW-1:0] beat(int f, int w, int c, int n);
    int g = c / PI;
    int y = n / (w * g), x = (n % (w * g)) / g, gr = n % g;
    logic [DW-1:0] d = '0;
    for (int l = 0; l < PI; l++) d[l*QA +: QA] = pix(f, y, x, gr * PI + l);
    return d;
  endfunction

  function automatic logic [WINW-1:0] exp_win(int f, int w, int c, int k, int n);
    int g = c / PI;
    int y = n / (w * g), x = (n % (w * g)) / g, gr = n % g;
    logic [WINW-1:0] e = '0;
    for (int r = 0; r < k; r++)
      for (int j = 0; j < k; j++)
        for (int l = 0; l < PI; l++) begin
          int yy = y - (k - 1 - r), xx = x - (k - 1 - j);
          if (xx >= 0) e[((r * K_MAX + j) * PI + l) * QA +: QA] = pix(f, yy, xx, gr * PI + l);
        end
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic [WINW-1:0] act, logic [WINW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(int f, int w, int c, int k, int rows);
    int g = c / PI;
    int tot = rows * w * g, n0 = (k - 1) * w * g;
    int nexp = tot - n0, n_in = 0, n_out = 0, cyc = 0;
    bit first = 1'b1;
    while (n_out < nexp && !done) begin
      @(negedge clk);
      in_valid  = (n_in < tot) && (cyc % 6 != 5);
      in_sof    = (n_in == 0);
      in_data   = beat(f, w, c, n_in);
      // R8: misleading config on every non-start beat
      width     = in_sof ? WW'(w) : WW'(1);
      chan      = in_sof ? CW'(c) : CW'(PI);
      ksize     = in_sof ? KW'(k) : ((k == 1) ? KW'(3) : KW'(1));
      out_ready = ((cyc * 7 + f) % 4) != 0;
      #(CLK_P/4);
      if (out_valid && !out_ready)
        check(!in_ready, "R7 ready under stall", WINW'(in_ready), '0);
      if (k == 1)
        check(out_valid == in_valid, "R6 bypass valid", WINW'(out_valid), WINW'(in_valid));
      if (out_valid && first) begin
        first = 1'b0;
        check(n_in >= n0 + ((k > 1) ? 1 : 0), "R4 first window timing", WINW'(n_in), WINW'(n0));
      end
      if (out_valid && out_ready) begin
        logic [WINW-1:0] e = exp_win(f, w, c, k, n0 + n_out);
        if (k == 1) check(out_win == e, "R6 bypass data", out_win, e);
        else check(out_win == e, "R1/R2/R3/R5/R8/R10 window", out_win, e);
        n_out++;
      end
      if (in_valid && in_ready) n_in++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    #(CLK_P/4);
    check(!out_valid, "R4 no extra window", WINW'(out_valid), '0);
    check(n_in == tot, "R7 all beats taken", WINW'(n_in), WINW'(tot));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check(!out_valid, "R9 reset state", WINW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(0, 4, 4, 3, 4);
    run_frame(1, 3, 2, 2, 4);
    run_frame(2, 2, 4, 1, 3);
    run_frame(3, 8, 4, 3, 3);
    run_frame(4, 1, 2, 3, 4);
    run_frame(5, 5, 2, 3, 5);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule